// File: doc/BRIEF.md
# Burst-Capable Synchronous Cache Data RAM

This block is a single-port synchronous memory meant to hold the data side of a secondary cache. Each word is 18 bits, split into a lower and an upper 9-bit byte lane, and the depth is set by an address-width parameter. Every input except the output enable is sampled on the rising clock edge. An access starts when one of two address strobes loads a new base address. One strobe belongs to the processor and the other to the cache controller.

Once a base address is loaded, the block runs a burst of up to four words from it. An internal 2-bit counter replaces the two lowest address bits, and those bits follow an interleaved order. An advance input moves the burst on or holds it in place for a wait state. Read data reaches the output one clock after its address is loaded or stepped. A valid flag goes with the data and is gated at once by the output enable.

Top module: `burst_cache_sram`

## Requirements
- R1: When the processor strobe and chip enable are both sampled low, the external address is loaded with the counter cleared, and the cycle is a read. The byte write enables and the controller strobe have no effect in that cycle, so memory is left unchanged.
- R2: When the processor strobe is low, chip enable is high and the controller strobe is high, nothing is loaded and the cycle acts as a burst continuation.
- R3: When the controller strobe is low and the processor strobe is not starting an access, the external address is loaded with the counter cleared. The cycle is a write if either byte write enable is low, and a read otherwise.
- R4: Chip enable is looked at only in cycles that load an address. While a burst continues, a high chip enable neither stops nor alters it.
- R5: In a continuation cycle, advance low increments the counter before the access. Advance high keeps the address, so the same word is accessed again.
- R6: The two low address bits of an access equal the base's low bits XOR the counter. The counter counts 0, 1, 2, 3 and then wraps to 0, which returns to the base word.
- R7: A write started by the processor strobe takes two cycles: the load cycle, then a cycle with both strobes high, at least one byte write enable low, and the data present. The data is written to the loaded address.
- R8: The lower byte write enable (active low) writes data bits 8..0 and the upper one writes bits 17..9. The other lane keeps its contents.
- R9: The valid flag is 1 only when output enable is low and the last sampled access was a read. Output enable acts without a clock. Data-out is all zeros whenever the flag is 0, including after a write cycle.
- R10: Read data and the valid flag appear one clock edge after the edge that sampled the read.
- R11: After synchronous reset the valid flag is 0 and no burst is active. Continuation cycles then access nothing.
- R12: A controller-strobe load with chip enable high deselects the block. That cycle and the continuation cycles after it access nothing until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| chip_en_n | input | 1 | Chip enable, active low, sampled on loads only |
| wr_lo_n | input | 1 | Lower-lane write enable, active low |
| wr_hi_n | input | 1 | Upper-lane write enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | External address |
| wdata | input | 18 | Write data |
| rdata | output | 18 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid, gated by oe_n |

## Verification
A strobe load and an ongoing burst step can fall in the same cycle, because the advance input stays low while a strobe interrupts the burst. The bench does this both on purpose (a processor strobe with chip enable high in the middle of a burst, and a processor strobe held together with the controller strobe and the write enables) and at random. A reference model built from the strobe priority rules judges which event wins, by the word returned and by whether memory changed.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
    localparam int CNT_W  = 2;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_kind_e;

    // decoded control inputs, all active high
    typedef struct packed {
        logic             proc;
        logic             ctrl;
        logic             adv;
        logic             ce;
        logic [LANES-1:0] we;
    } strobe_t;

    function automatic logic [CNT_W-1:0] burst_low(input logic [CNT_W-1:0] base_lo,
                                                   input logic [CNT_W-1:0] step);
        return base_lo ^ step;
    endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  strobe_t                stb,
    input  logic [ADDR_W-1:0]      addr,
    output acc_kind_e              kind,
    output logic [ADDR_W-1:0]      eff_addr,
    output logic [LANES-1:0]       lane_we
);

    logic              active_q, active_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              load_p, load_c, load;

    always_comb begin
        load_p   = stb.proc && stb.ce;
        load_c   = !load_p && stb.ctrl;
        load     = load_p || load_c;
        active_d = active_q;
        base_d   = base_q;
        cnt_d    = cnt_q;
        if (load) begin
            base_d   = addr;
            cnt_d    = '0;
            active_d = load_p ? 1'b1 : stb.ce;
        end else if (active_q && stb.adv) begin
            cnt_d = cnt_q + 1'b1;
        end
        eff_addr = {base_d[ADDR_W-1:CNT_W], burst_low(base_d[CNT_W-1:0], cnt_d)};
        if (load_p)
            kind = ACC_RD;
        else if (active_d)
            kind = (|stb.we) ? ACC_WR : ACC_RD;
        else
            kind = ACC_IDLE;
        lane_we = (kind == ACC_WR) ? stb.we : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else begin
            active_q <= active_d;
            base_q   <= base_d;
            cnt_q    <= cnt_d;
        end
    end

    // R6: a load restarts the burst at the loaded word
    assert_load_origin_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == '0 && base_q == $past(addr)));

    // R4: outside a load the selection state never changes
    assert_ce_blind_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> (active_q == $past(active_q)));

    // R5: advance high in a continuation keeps the counter
    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && !stb.adv) |=> $stable(cnt_q));

endmodule

// File: rtl/lane_array.sv
module lane_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  acc_kind_e              kind,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [LANES-1:0]       lane_we,
    input  logic [WORD_W-1:0]      wdata,
    output logic [WORD_W-1:0]      rdata_q,
    output logic                   rd_vld
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            if (kind == ACC_RD)
                rdata_q[g*LANE_W +: LANE_W] <= mem[addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_vld <= 1'b0;
        else
            rd_vld <= (kind == ACC_RD);
    end

    // R9: a write cycle never leaves valid read data behind
    assert_wr_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (|lane_we) |=> !rd_vld);

endmodule

// File: rtl/burst_cache_sram.sv
module burst_cache_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              adv_n,
    input  logic              chip_en_n,
    input  logic              wr_lo_n,
    input  logic              wr_hi_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [17:0]       wdata,
    output logic [17:0]       rdata,
    output logic              rvalid
);

    strobe_t          stb;
    acc_kind_e        kind;
    logic [ADDR_W-1:0] eff_addr;
    logic [LANES-1:0] lane_we;
    logic [WORD_W-1:0] rdata_q;
    logic             rd_vld;

    always_comb begin
        stb.proc = !proc_strobe_n;
        stb.ctrl = !ctrl_strobe_n;
        stb.adv  = !adv_n;
        stb.ce   = !chip_en_n;
        stb.we   = {!wr_hi_n, !wr_lo_n};
    end

    burst_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .stb      (stb),
        .addr     (addr),
        .kind     (kind),
        .eff_addr (eff_addr),
        .lane_we  (lane_we)
    );

    lane_array #(.ADDR_W(ADDR_W)) arr_i (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .addr    (eff_addr),
        .lane_we (lane_we),
        .wdata   (wdata),
        .rdata_q (rdata_q),
        .rd_vld  (rd_vld)
    );

    assign rvalid = rd_vld && !oe_n;
    assign rdata  = rvalid ? rdata_q : '0;

    // R1: a selected processor strobe always produces a read
    assert_proc_read_R1: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n && !chip_en_n) |=> rd_vld);

    // R9: output enable high keeps the flag low
    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !rvalid);

endmodule

// File: tb/burst_cache_sram_tb_top.sv
`timescale 1ns/1ps
module burst_cache_sram_tb_top;

    localparam int AW = 10;
    localparam int DEP = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic p_n = 1, c_n = 1, a_n = 1, e_n = 1, lo_n = 1, hi_n = 1, oe_n = 0;
    logic [AW-1:0] addr = '0;
    logic [17:0] wd = '0;
    logic [17:0] rdata;
    logic rvalid;

    int n_chk = 0;
    int n_err = 0;

    logic [17:0] m_mem [DEP];
    logic m_active = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_cnt = '0;
    logic m_valid = 0;
    logic [17:0] m_data = '0;

    always #10 clk = ~clk;

    burst_cache_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .proc_strobe_n(p_n), .ctrl_strobe_n(c_n),
        .adv_n(a_n), .chip_en_n(e_n), .wr_lo_n(lo_n), .wr_hi_n(hi_n),
        .oe_n(oe_n), .addr(addr), .wdata(wd), .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [17:0] pat(input int a);
        return 18'(a * 37 + 5);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model of one sampled cycle, from the requirements
    task automatic model_step();
        bit ldp, ldc, rd, wr;
        logic [AW-1:0] ea;
        ldp = !p_n && !e_n;
        ldc = !ldp && !c_n;
        rd = 0; wr = 0; ea = '0;
        if (ldp || ldc) begin
            m_base = addr; m_cnt = 2'd0;
            m_active = ldp ? 1'b1 : !e_n;
        end else if (m_active && !a_n) begin
            m_cnt = m_cnt + 2'd1;
        end
        ea = {m_base[AW-1:2], m_base[1:0] ^ m_cnt};
        if (ldp) rd = 1;
        else if (m_active) begin
            if (!lo_n || !hi_n) wr = 1; else rd = 1;
        end
        if (wr) begin
            if (!lo_n) m_mem[ea][8:0] = wd[8:0];
            if (!hi_n) m_mem[ea][17:9] = wd[17:9];
        end
        m_valid = rd;
        if (rd) m_data = m_mem[ea];
    endtask

    task automatic drive(input bit p, c, a, e, lo, hi, input logic [AW-1:0] ad,
                         input logic [17:0] d, input string tag);
        bit ev;
        p_n = p; c_n = c; a_n = a; e_n = e; lo_n = lo; hi_n = hi; addr = ad; wd = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        ev = m_valid && !oe_n;
        chk(rvalid === ev, {tag, " valid"}, 32'(rvalid), 32'(ev));
        chk(rdata === (ev ? m_data : 18'd0), {tag, " data"}, 32'(rdata), 32'(ev ? m_data : 18'd0));
    endtask

    task automatic exp_rd(input logic [17:0] d, input string tag);
        chk(rvalid === 1'b1 && rdata === d, tag, {13'd0, rvalid, rdata}, {13'd0, 1'b1, d});
    endtask

    task automatic exp_idle(input string tag);
        chk(rvalid === 1'b0 && rdata === 18'd0, tag, {13'd0, rvalid, rdata}, 32'd0);
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        exp_idle("R11 after reset");
        drive(1,1,0,0,1,1, 10'h0, 18'h0, "R11");
        exp_idle("R11 continuation without burst");

        for (int i = 0; i < DEP; i++)
            drive(1,0,1,0,0,0, AW'(i), pat(i), "R3 preload");
        exp_idle("R9 write leaves output quiet");

        drive(1,0,1,0,1,1, 10'h025, 18'h0, "R10");
        exp_rd(pat(10'h025), "R3 R10 controller read one edge later");

        // interleaved burst from low bits 2'b10
        drive(1,0,1,0,1,1, 10'h046, 18'h0, "R6");
        exp_rd(pat(10'h046), "R6 first");
        drive(1,1,0,0,1,1, 10'h3ff, 18'h0, "R6");
        exp_rd(pat(10'h047), "R6 step1");
        drive(1,1,0,0,1,1, 10'h3ff, 18'h0, "R6");
        exp_rd(pat(10'h044), "R6 step2");
        drive(1,1,0,0,1,1, 10'h3ff, 18'h0, "R6");
        exp_rd(pat(10'h045), "R6 step3");
        drive(1,1,0,0,1,1, 10'h3ff, 18'h0, "R6");
        exp_rd(pat(10'h046), "R6 wrap to base");

        drive(1,0,1,0,1,1, 10'h080, 18'h0, "R5");
        drive(1,1,0,0,1,1, 10'h0, 18'h0, "R5");
        exp_rd(pat(10'h081), "R5 advance");
        drive(1,1,1,0,1,1, 10'h0, 18'h0, "R5");
        exp_rd(pat(10'h081), "R5 wait state");
        drive(1,1,0,0,1,1, 10'h0, 18'h0, "R5");
        exp_rd(pat(10'h082), "R5 resume");
        drive(1,1,0,1,1,1, 10'h0, 18'h0, "R4");
        exp_rd(pat(10'h083), "R4 chip enable high mid-burst");
        drive(0,1,0,1,1,1, 10'h200, 18'h0, "R2");
        exp_rd(pat(10'h080), "R2 ignored strobe continues burst");

        drive(0,0,1,0,0,0, 10'h123, 18'h3ffff, "R1");
        exp_rd(pat(10'h123), "R1 processor strobe reads");
        drive(1,0,1,0,1,1, 10'h123, 18'h0, "R1");
        exp_rd(pat(10'h123), "R1 memory untouched");

        drive(1,0,0,1,1,1, 10'h010, 18'h0, "R12");
        exp_idle("R12 deselect load");
        drive(1,1,0,0,1,1, 10'h0, 18'h0, "R12");
        exp_idle("R12 stays deselected");

        drive(0,1,1,0,1,1, 10'h155, 18'h0, "R7");
        exp_rd(pat(10'h155), "R7 load cycle reads");
        drive(1,1,1,0,0,0, 10'h000, 18'h2a5a5, "R7");
        exp_idle("R7 second cycle writes");
        drive(1,0,1,0,1,1, 10'h155, 18'h0, "R7");
        exp_rd(18'h2a5a5, "R7 data stored");

        drive(1,0,1,0,0,1, 10'h060, 18'h15a5a, "R8");
        drive(1,0,1,0,1,1, 10'h060, 18'h0, "R8");
        exp_rd({pat(10'h060)}[17:9] == 9'd0 ? {9'd0, 9'h05a} : {pat(10'h060)} & 18'h3fe00 | 18'h0005a, "R8 lower lane");
        drive(1,0,1,0,1,0, 10'h061, 18'h15a5a, "R8");
        drive(1,0,1,0,1,1, 10'h061, 18'h0, "R8");
        exp_rd((18'h15a5a & 18'h3fe00) | (pat(10'h061) & 18'h001ff), "R8 upper lane");

        #3 oe_n = 1;
        #1 exp_idle("R9 oe high without clock");
        oe_n = 0;
        #1 exp_rd((18'h15a5a & 18'h3fe00) | (pat(10'h061) & 18'h001ff), "R9 oe low again");

        for (int k = 0; k < 4000; k++) begin
            oe_n = ($urandom % 5) == 0;
            drive(($urandom % 7) != 0, ($urandom % 5) != 0, $urandom % 2 == 1,
                  ($urandom % 5) == 0, ($urandom % 3) != 0, ($urandom % 3) != 0,
                  AW'($urandom), 18'($urandom), "R10 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule